// File: doc/BRIEF.md
# Fused Multiply-Add NaN Operand Selector

This unit decides which operand supplies the NaN result of a fused multiply-add (A*B)+C once at least one input is a NaN. It receives a two-bit class for each of the three operands, a flag saying that the product is infinity times zero, and a policy code. It returns a two-bit choice of A, B, C or the default NaN. It also returns two invalid-operation requests: one that the policy raises for the infinity-times-zero case, and one raised whenever any input is a signalling NaN.

The choice goes to a later stage that quiets the chosen payload and muxes it onto the result. That stage, the arithmetic and the flag accumulation all sit outside this block. The three results are registered once, so they appear one clock after their inputs are applied. An asynchronous active-low reset clears them, and the block's own synchronizer releases that reset on a clock edge.

Policy codes: 0, 1, 2, 3 and 4 are fixed priority schemes. 5 and 6 are the first-NaN and last-NaN variants of one scheme. 7 is the fallback.

Top module: `fnsel_top`

## Requirements
- R1: Class codes are 0 = not a NaN, 1 = quiet NaN, 2 = signalling NaN; code 3 is treated as not a NaN. Selection codes are 0 = A, 1 = B, 2 = C, 3 = default NaN. All three outputs appear in the cycle after the inputs are sampled, and the default NaN is chosen only under policies 0, 1 and 4.
- R2: Policy 0: infzero with C a quiet NaN requests invalid and selects default. Otherwise the first match wins: signalling C, signalling A, signalling B, NaN C, NaN A; else B.
- R3: Policy 1: infzero requests invalid and selects default. Otherwise the first match wins: signalling A, B, C, then NaN A, NaN B; else C.
- R4: Policy 2: infzero requests invalid and selects C. Otherwise the first match wins: signalling C, A, B, then NaN C, NaN A; else B.
- R5: Policy 3: infzero requests invalid and selects C. Otherwise the first match wins: NaN A, NaN C; else B.
- R6: Policy 4 always selects default and requests invalid exactly when infzero is set.
- R7: Policy 5: infzero requests invalid and selects C. Otherwise the first match wins: NaN A, NaN B; else C.
- R8: Policy 6: infzero requests invalid and selects C. Otherwise the first match wins: NaN C, NaN B; else A.
- R9: Policy 7: the first match wins among NaN A, NaN B; else C. The invalid request is never raised under this policy, whatever infzero is.
- R10: The signalling-NaN invalid output is 1 exactly when at least one class input is 2.
- R11: While reset is active, and until the synchronizer releases it, all outputs are 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 3 | Priority policy code 0..7 |
| cls_a_i | input | 2 | Class of operand A |
| cls_b_i | input | 2 | Class of operand B |
| cls_c_i | input | 2 | Class of addend C |
| infzero_i | input | 1 | Product is infinity times zero |
| sel_o | output | 2 | Chosen source: 0 A, 1 B, 2 C, 3 default NaN |
| inv_req_o | output | 1 | Invalid request from the infzero rule |
| snan_inv_o | output | 1 | Invalid request from any signalling input |

## Verification
The bench targets the policies where a signalling NaN in a later operand must override a quiet NaN in an earlier one. A design that ranked by position alone would pass a quiet A through in place of a signalling C. The infzero interaction gets separate attention: a policy 0 design that forgot the quiet-C condition would raise invalid on any infinity-times-zero. Policies 3 and 5 must pass C through even when C is not a NaN. Class code 3 is mixed in throughout, so a decoder that took it for signalling would raise false invalids and reorder selections. The reset window is also checked, to show that a result does not leak out before the release.

// File: rtl/fnsel_pkg.sv
package fnsel_pkg;
  localparam int CLS_W  = 2;
  localparam int POL_W  = 3;
  localparam int SEL_W  = 2;
  localparam int N_OPS  = 3;
  localparam int OP_A   = 0;
  localparam int OP_B   = 1;
  localparam int OP_C   = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2,
    CLS_RSVD = 2'd3
  } fclass_e;

  typedef enum logic [POL_W-1:0] {
    POL_Q0   = 3'd0,
    POL_Q1   = 3'd1,
    POL_Q2   = 3'd2,
    POL_Q3   = 3'd3,
    POL_Q4   = 3'd4,
    POL_Q5F  = 3'd5,
    POL_Q5L  = 3'd6,
    POL_FB   = 3'd7
  } policy_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_DFLT = 2'd3
  } sel_e;
endpackage

// File: rtl/fnsel_decode.sv
module fnsel_decode
  import fnsel_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output logic             nan_o,
  output logic             snan_o
);
  always_comb begin
    nan_o  = 1'b0;
    snan_o = 1'b0;
    case (cls_i)
      CLS_QNAN: nan_o = 1'b1;
      CLS_SNAN: begin
        nan_o  = 1'b1;
        snan_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fnsel_prio.sv
module fnsel_prio
  import fnsel_pkg::*;
(
  input  logic [N_OPS-1:0] nan_i,
  input  logic [N_OPS-1:0] snan_i,
  input  logic [POL_W-1:0] policy_i,
  input  logic             infzero_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [N_OPS-1:0] qnan;
  assign qnan = nan_i & ~snan_i;

  always_comb begin
    sel_o = SEL_C;
    case (policy_e'(policy_i))
      POL_Q0: begin
        if (infzero_i && qnan[OP_C]) sel_o = SEL_DFLT;
        else if (snan_i[OP_C])       sel_o = SEL_C;
        else if (snan_i[OP_A])       sel_o = SEL_A;
        else if (snan_i[OP_B])       sel_o = SEL_B;
        else if (nan_i[OP_C])        sel_o = SEL_C;
        else if (nan_i[OP_A])        sel_o = SEL_A;
        else                         sel_o = SEL_B;
      end
      POL_Q1: begin
        if (infzero_i)               sel_o = SEL_DFLT;
        else if (snan_i[OP_A])       sel_o = SEL_A;
        else if (snan_i[OP_B])       sel_o = SEL_B;
        else if (snan_i[OP_C])       sel_o = SEL_C;
        else if (nan_i[OP_A])        sel_o = SEL_A;
        else if (nan_i[OP_B])        sel_o = SEL_B;
        else                         sel_o = SEL_C;
      end
      POL_Q2: begin
        if (infzero_i)               sel_o = SEL_C;
        else if (snan_i[OP_C])       sel_o = SEL_C;
        else if (snan_i[OP_A])       sel_o = SEL_A;
        else if (snan_i[OP_B])       sel_o = SEL_B;
        else if (nan_i[OP_C])        sel_o = SEL_C;
        else if (nan_i[OP_A])        sel_o = SEL_A;
        else                         sel_o = SEL_B;
      end
      POL_Q3: begin
        if (infzero_i)               sel_o = SEL_C;
        else if (nan_i[OP_A])        sel_o = SEL_A;
        else if (nan_i[OP_C])        sel_o = SEL_C;
        else                         sel_o = SEL_B;
      end
      POL_Q4: sel_o = SEL_DFLT;
      POL_Q5F: begin
        if (infzero_i)               sel_o = SEL_C;
        else if (nan_i[OP_A])        sel_o = SEL_A;
        else if (nan_i[OP_B])        sel_o = SEL_B;
        else                         sel_o = SEL_C;
      end
      POL_Q5L: begin
        if (infzero_i)               sel_o = SEL_C;
        else if (nan_i[OP_C])        sel_o = SEL_C;
        else if (nan_i[OP_B])        sel_o = SEL_B;
        else                         sel_o = SEL_A;
      end
      default: begin
        if (nan_i[OP_A])             sel_o = SEL_A;
        else if (nan_i[OP_B])        sel_o = SEL_B;
        else                         sel_o = SEL_C;
      end
    endcase
  end
endmodule

// File: rtl/fnsel_flags.sv
module fnsel_flags
  import fnsel_pkg::*;
(
  input  logic [N_OPS-1:0] nan_i,
  input  logic [N_OPS-1:0] snan_i,
  input  logic [POL_W-1:0] policy_i,
  input  logic             infzero_i,
  output logic             inv_req_o,
  output logic             snan_inv_o
);
  always_comb begin
    case (policy_e'(policy_i))
      POL_Q0:  inv_req_o = infzero_i && nan_i[OP_C] && !snan_i[OP_C];
      POL_FB:  inv_req_o = 1'b0;
      default: inv_req_o = infzero_i;
    endcase
  end

  assign snan_inv_o = |snan_i;
endmodule

// File: rtl/fnsel_top.sv
module fnsel_top
  import fnsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POL_W-1:0] policy_i,
  input  logic [CLS_W-1:0] cls_a_i,
  input  logic [CLS_W-1:0] cls_b_i,
  input  logic [CLS_W-1:0] cls_c_i,
  input  logic             infzero_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             inv_req_o,
  output logic             snan_inv_o
);
  // reset release synchronizer
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [CLS_W-1:0] cls_vec [N_OPS];
  assign cls_vec[OP_A] = cls_a_i;
  assign cls_vec[OP_B] = cls_b_i;
  assign cls_vec[OP_C] = cls_c_i;

  logic [N_OPS-1:0] nan_v, snan_v;
  for (genvar g = 0; g < N_OPS; g++) begin : g_dec
    fnsel_decode u_dec (
      .cls_i  (cls_vec[g]),
      .nan_o  (nan_v[g]),
      .snan_o (snan_v[g])
    );
  end

  logic [SEL_W-1:0] sel_d;
  logic             inv_d, snan_d;

  fnsel_prio u_prio (
    .nan_i     (nan_v),
    .snan_i    (snan_v),
    .policy_i  (policy_i),
    .infzero_i (infzero_i),
    .sel_o     (sel_d)
  );

  fnsel_flags u_flags (
    .nan_i      (nan_v),
    .snan_i     (snan_v),
    .policy_i   (policy_i),
    .infzero_i  (infzero_i),
    .inv_req_o  (inv_d),
    .snan_inv_o (snan_d)
  );

  // output register, enabled once reset is released
  logic             out_en;
  logic [SEL_W-1:0] sel_q;
  logic             inv_q, snan_q;
  assign out_en = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      inv_q  <= 1'b0;
      snan_q <= 1'b0;
    end else if (out_en) begin
      sel_q  <= sel_d;
      inv_q  <= inv_d;
      snan_q <= snan_d;
    end
  end

  assign sel_o      = sel_q;
  assign inv_req_o  = inv_q;
  assign snan_inv_o = snan_q;

  // R6
  q4_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_q) && $past(policy_i) == POL_Q4) |-> (sel_q == SEL_DFLT));

  // R4 R5 R7 R8
  iz_passc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_q) && $past(infzero_i) &&
     ($past(policy_i) == POL_Q2 || $past(policy_i) == POL_Q3 ||
      $past(policy_i) == POL_Q5F || $past(policy_i) == POL_Q5L))
    |-> (sel_q == SEL_C && inv_q));

  // R9
  fb_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_q) && $past(policy_i) == POL_FB) |-> !inv_q);

  // R1
  dflt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_q) && sel_q == SEL_DFLT) |->
    ($past(policy_i) == POL_Q0 || $past(policy_i) == POL_Q1 ||
     $past(policy_i) == POL_Q4));

  // R10
  snan_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_q) && ($past(cls_a_i) == CLS_SNAN || $past(cls_b_i) == CLS_SNAN ||
                      $past(cls_c_i) == CLS_SNAN)) |-> snan_q);

  // R11
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> (sel_q == '0 && !inv_q && !snan_q));
endmodule

// File: tb/fnsel_top_tb.sv
`timescale 1ns/1ps
module fnsel_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] policy_i;
  logic [1:0] cls_a_i, cls_b_i, cls_c_i;
  logic       infzero_i;
  logic [1:0] sel_o;
  logic       inv_req_o, snan_inv_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fnsel_top u_dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy_i),
    .cls_a_i(cls_a_i), .cls_b_i(cls_b_i), .cls_c_i(cls_c_i),
    .infzero_i(infzero_i), .sel_o(sel_o),
    .inv_req_o(inv_req_o), .snan_inv_o(snan_inv_o)
  );

  function automatic string pol_tag(input int p);
    case (p)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; 6: return "R8"; default: return "R9";
    endcase
  endfunction

  // behavioural reference: each step is an operand index plus 10 if any NaN
  // matches (else only signalling); first hit wins, else the tail operand
  function automatic void ref_model(input int p, input int ca, input int cb,
                                    input int cc, input bit iz,
                                    output int s, output bit inv, output bit sv);
    int cl[3];
    int steps[$];
    int tail;
    int iz_act;   // 0 none, 1 default NaN, 2 take C
    cl[0] = ca; cl[1] = cb; cl[2] = cc;
    sv  = (ca == 2) || (cb == 2) || (cc == 2);
    inv = 1'b0;
    iz_act = 0;
    tail = 2;
    case (p)
      0: begin steps = '{2, 0, 1, 12, 10}; tail = 1;
               if (iz && cc == 1) iz_act = 1; end
      1: begin steps = '{0, 1, 2, 10, 11}; tail = 2; if (iz) iz_act = 1; end
      2: begin steps = '{2, 0, 1, 12, 10}; tail = 1; if (iz) iz_act = 2; end
      3: begin steps = '{10, 12};          tail = 1; if (iz) iz_act = 2; end
      4: begin steps = {}; tail = 3; inv = iz; end
      5: begin steps = '{10, 11};          tail = 2; if (iz) iz_act = 2; end
      6: begin steps = '{12, 11};          tail = 0; if (iz) iz_act = 2; end
      default: begin steps = '{10, 11};    tail = 2; end
    endcase
    if (iz_act != 0) begin
      inv = 1'b1;
      s = (iz_act == 1) ? 3 : 2;
      return;
    end
    foreach (steps[k]) begin
      int op = steps[k] % 10;
      bit any = steps[k] >= 10;
      if ((cl[op] == 2) || (any && cl[op] == 1)) begin
        s = op;
        return;
      end
    end
    s = tail;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    policy_i = 3'd4; cls_a_i = 2'd2; cls_b_i = 2'd2; cls_c_i = 2'd2; infzero_i = 1'b1;
    repeat (3) @(negedge clk);
    // R11 outputs held at zero in reset
    check("R11", "sel in reset", sel_o, 0);
    check("R11", "inv in reset", inv_req_o, 0);
    check("R11", "snan in reset", snan_inv_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 still quiet while the release is synchronised
    check("R11", "sel during release", sel_o, 0);
    check("R11", "snan during release", snan_inv_o, 0);
    repeat (3) @(negedge clk);

    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          for (int c = 0; c < 4; c++) begin
            for (int z = 0; z < 2; z++) begin
              int es; bit ei, esv;
              policy_i = 3'(p); cls_a_i = 2'(a); cls_b_i = 2'(b);
              cls_c_i = 2'(c); infzero_i = z[0];
              ref_model(p, a, b, c, z[0], es, ei, esv);
              @(posedge clk);
              @(negedge clk);
              // R1 one-cycle latency and encodings, per-policy rule
              check({"R1/", pol_tag(p)}, $sformatf("sel p=%0d a=%0d b=%0d c=%0d iz=%0d",
                    p, a, b, c, z), sel_o, es);
              check(pol_tag(p), $sformatf("inv p=%0d a=%0d b=%0d c=%0d iz=%0d",
                    p, a, b, c, z), inv_req_o, ei);
              // R10
              check("R10", $sformatf("snan a=%0d b=%0d c=%0d", a, b, c), snan_inv_o, esv);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule